// File: doc/BRIEF.md
# Pairwise Data Hazard Classifier

This block takes the register fields of two instructions in program order, an older one (i) and a younger one (j), and reports which data dependencies exist between them. Each instruction offers one destination field and a number of source fields. Every field carries its own valid bit. The block tests three set intersections:

- the writes of i against the reads of j, which is read-after-write;
- the reads of i against the writes of j, which is write-after-read;
- the writes of i against the writes of j, which is write-after-write.

The result appears as three separate flags plus a summary flag.

All comparisons are combinational, and the flags are captured in one register stage. Scheduling logic upstream can use the flags to decide whether j may issue, overtake i, or retire ahead of it. Immediate operands are presented as invalid source fields, so they never take part in a comparison. Instruction decode, stalling and forwarding belong to other blocks.

Top module: `hazard_classifier`

## Requirements
- R1: `raw_o` is 1 when the destination of i is valid and equals a valid source field of j.
- R2: `war_o` is 1 when a valid source field of i equals the valid destination of j.
- R3: `waw_o` is 1 when both destinations are valid and equal.
- R4: The three flags are independent. With i = R3←R2+R1 and j = R2←R3+immediate, `raw_o`=1, `war_o`=1 and `waw_o`=0.
- R5: A field whose valid bit is 0 never matches, whatever its identifier. This includes an immediate operand that sits in a source slot. Register 0 compares like any other register.
- R6: `any_o` is the OR of `raw_o`, `war_o` and `waw_o`.
- R7: The outputs in a cycle reflect the inputs sampled at the preceding rising edge of `clk`, a latency of one cycle.
- R8: While `rst` is high at a rising edge, every output is 0 after that edge.
- R9: Source slot k occupies bits [k*5 +: 5] of a source bus, and bit k of the matching source-valid vector qualifies it. A match in either slot counts.
- R10: When both sources of j name i's destination, `raw_o` is a plain 1, not a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| i_dst_vld | input | 1 | Destination of older instruction is valid |
| i_dst_id | input | 5 | Destination register of older instruction |
| i_src_vld | input | 2 | Per-slot valid bits of older instruction sources |
| i_src_id | input | 10 | Source registers of older instruction, slot k at [k*5 +: 5] |
| j_dst_vld | input | 1 | Destination of younger instruction is valid |
| j_dst_id | input | 5 | Destination register of younger instruction |
| j_src_vld | input | 2 | Per-slot valid bits of younger instruction sources |
| j_src_id | input | 10 | Source registers of younger instruction, slot k at [k*5 +: 5] |
| raw_o | output | 1 | Read-after-write detected |
| war_o | output | 1 | Write-after-read detected |
| waw_o | output | 1 | Write-after-write detected |
| any_o | output | 1 | At least one hazard detected |

## Verification
The only internal state is the three-bit flag register. A wrong comparison or a stuck flag bit therefore shows up at the outputs in the very next cycle, on the operand pattern that exercises it. The scoreboard runs patterns in which each class is set alone, all three are set together, and none is set. This separates a swapped or merged intersection from a correct one at the first such pattern. Further patterns place a match in only the second slot, or give a matching identifier a cleared valid bit. These catch wrong slicing or ignored valid bits the cycle after they are applied. A reset applied while hazardous inputs are present must clear the outputs on the following edge.

// File: rtl/hazard_pkg.sv
`timescale 1ns/1ps
package hazard_pkg;

   typedef struct packed {
      logic raw;
      logic war;
      logic waw;
   } hz_flags_t;

   function automatic logic hz_any(input hz_flags_t f);
      return f.raw | f.war | f.waw;
   endfunction

endpackage

// File: rtl/hz_set_probe.sv
`timescale 1ns/1ps
// Tests whether one qualified register identifier is a member of a set
// of qualified identifiers. DECODE picks the implementation variant.
module hz_set_probe #(
   parameter int REG_W  = 5,
   parameter int SET_N  = 2,
   parameter bit DECODE = 1'b0
) (
   input  logic                   key_vld,
   input  logic [REG_W-1:0]       key_id,
   input  logic [SET_N-1:0]       set_vld,
   input  logic [SET_N*REG_W-1:0] set_id,
   output logic                   hit
);

   generate
      if (DECODE == 1'b0) begin : g_cmp
         logic [SET_N-1:0] eq;
         for (genvar k = 0; k < SET_N; k++) begin : g_slot
            assign eq[k] = set_vld[k] && (set_id[k*REG_W +: REG_W] == key_id);
         end
         assign hit = key_vld && (|eq);
      end else begin : g_dec
         localparam int NREG = 1 << REG_W;
         logic [NREG-1:0] key_oh;
         logic [NREG-1:0] set_oh;
         always_comb begin
            key_oh = '0;
            set_oh = '0;
            if (key_vld) key_oh[key_id] = 1'b1;
            for (int k = 0; k < SET_N; k++) begin
               if (set_vld[k]) set_oh[set_id[k*REG_W +: REG_W]] = 1'b1;
            end
         end
         assign hit = |(key_oh & set_oh);
      end
   endgenerate

endmodule

// File: rtl/hz_flag_stage.sv
`timescale 1ns/1ps
module hz_flag_stage
   import hazard_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  hz_flags_t d,
   output hz_flags_t q
);

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

endmodule

// File: rtl/hazard_classifier.sv
`timescale 1ns/1ps
module hazard_classifier
   import hazard_pkg::*;
#(
   parameter int REG_W        = 5,
   parameter int NUM_SRC      = 2,
   parameter bit MATCH_DECODE = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     i_dst_vld,
   input  logic [REG_W-1:0]         i_dst_id,
   input  logic [NUM_SRC-1:0]       i_src_vld,
   input  logic [NUM_SRC*REG_W-1:0] i_src_id,
   input  logic                     j_dst_vld,
   input  logic [REG_W-1:0]         j_dst_id,
   input  logic [NUM_SRC-1:0]       j_src_vld,
   input  logic [NUM_SRC*REG_W-1:0] j_src_id,
   output logic                     raw_o,
   output logic                     war_o,
   output logic                     waw_o,
   output logic                     any_o
);

   localparam int SRC_BUS_W = NUM_SRC * REG_W;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_regw
         $error("hazard_classifier: REG_W must lie in 1..8");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_nsrc
         $error("hazard_classifier: NUM_SRC must lie in 1..4");
      end
      if (SRC_BUS_W != $bits(i_src_id)) begin : g_bad_bus
         $error("hazard_classifier: source bus width mismatch");
      end
   endgenerate

   hz_flags_t flags_d;
   hz_flags_t flags_q;

   // older write against younger reads
   hz_set_probe #(.REG_W(REG_W), .SET_N(NUM_SRC), .DECODE(MATCH_DECODE)) u_raw (
      .key_vld (i_dst_vld),
      .key_id  (i_dst_id),
      .set_vld (j_src_vld),
      .set_id  (j_src_id),
      .hit     (flags_d.raw)
   );

   // younger write against older reads
   hz_set_probe #(.REG_W(REG_W), .SET_N(NUM_SRC), .DECODE(MATCH_DECODE)) u_war (
      .key_vld (j_dst_vld),
      .key_id  (j_dst_id),
      .set_vld (i_src_vld),
      .set_id  (i_src_id),
      .hit     (flags_d.war)
   );

   // both writes
   hz_set_probe #(.REG_W(REG_W), .SET_N(1), .DECODE(MATCH_DECODE)) u_waw (
      .key_vld (i_dst_vld),
      .key_id  (i_dst_id),
      .set_vld (j_dst_vld),
      .set_id  (j_dst_id),
      .hit     (flags_d.waw)
   );

   hz_flag_stage u_stage (
      .clk (clk),
      .rst (rst),
      .d   (flags_d),
      .q   (flags_q)
   );

   assign raw_o = flags_q.raw;
   assign war_o = flags_q.war;
   assign waw_o = flags_q.waw;
   assign any_o = hz_any(flags_q);

endmodule

// File: rtl/hazard_classifier_chk.sv
`timescale 1ns/1ps
module hazard_classifier_chk #(
   parameter int REG_W   = 5,
   parameter int NUM_SRC = 2
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     i_dst_vld,
   input logic [REG_W-1:0]         i_dst_id,
   input logic [NUM_SRC-1:0]       i_src_vld,
   input logic [NUM_SRC*REG_W-1:0] i_src_id,
   input logic                     j_dst_vld,
   input logic [REG_W-1:0]         j_dst_id,
   input logic [NUM_SRC-1:0]       j_src_vld,
   input logic [NUM_SRC*REG_W-1:0] j_src_id,
   input logic                     raw_o,
   input logic                     war_o,
   input logic                     waw_o,
   input logic                     any_o
);

   logic raw_now, war_now, waw_now;
   logic seen_edge = 1'b0;

   always_comb begin
      raw_now = 1'b0;
      war_now = 1'b0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (i_dst_vld && j_src_vld[k] && i_dst_id == j_src_id[k*REG_W +: REG_W]) raw_now = 1'b1;
         if (j_dst_vld && i_src_vld[k] && j_dst_id == i_src_id[k*REG_W +: REG_W]) war_now = 1'b1;
      end
      waw_now = i_dst_vld && j_dst_vld && (i_dst_id == j_dst_id);
   end

   always_ff @(posedge clk) seen_edge <= 1'b1;

   p_raw_match_r1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (raw_o == $past(raw_now)));

   p_war_match_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (war_o == $past(war_now)));

   p_waw_match_r3: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (waw_o == $past(waw_now)));

   p_invalid_dst_r5: assert property (@(posedge clk) disable iff (rst)
      $past(!i_dst_vld || !j_dst_vld) |-> !waw_o);

   p_any_or_r6: assert property (@(posedge clk) disable iff (rst)
      any_o == (raw_o || war_o || waw_o));

   p_reset_clear_r8: assert property (@(posedge clk)
      (seen_edge && $past(rst)) |-> !(raw_o || war_o || waw_o || any_o));

endmodule

bind hazard_classifier hazard_classifier_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/hazard_classifier_tb_top.sv
`timescale 1ns/1ps
module hazard_classifier_tb_top;

   localparam int RW = 5;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          i_dst_vld = 1'b0;
   logic [RW-1:0] i_dst_id = '0;
   logic [NS-1:0] i_src_vld = '0;
   logic [NS*RW-1:0] i_src_id = '0;
   logic          j_dst_vld = 1'b0;
   logic [RW-1:0] j_dst_id = '0;
   logic [NS-1:0] j_src_vld = '0;
   logic [NS*RW-1:0] j_src_id = '0;
   logic raw_o, war_o, waw_o, any_o;

   int n_checks = 0;
   int n_fail   = 0;
   logic [2:0] exp_q[$];
   string      tag_q[$];
   bit         done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   hazard_classifier dut_i (
      .clk(clk), .rst(rst),
      .i_dst_vld(i_dst_vld), .i_dst_id(i_dst_id),
      .i_src_vld(i_src_vld), .i_src_id(i_src_id),
      .j_dst_vld(j_dst_vld), .j_dst_id(j_dst_id),
      .j_src_vld(j_src_vld), .j_src_id(j_src_id),
      .raw_o(raw_o), .war_o(war_o), .waw_o(waw_o), .any_o(any_o)
   );

   // model: {raw, war, waw} from set intersections
   function automatic logic [2:0] model(
      input logic idv, input logic [RW-1:0] id, input logic [1:0] isv,
      input logic [RW-1:0] is0, input logic [RW-1:0] is1,
      input logic jdv, input logic [RW-1:0] jd, input logic [1:0] jsv,
      input logic [RW-1:0] js0, input logic [RW-1:0] js1);
      logic r, w, o;
      r = idv && ((jsv[0] && js0 == id) || (jsv[1] && js1 == id));
      w = jdv && ((isv[0] && is0 == jd) || (isv[1] && is1 == jd));
      o = idv && jdv && (id == jd);
      return {r, w, o};
   endfunction

   // driver: apply one pattern at a falling edge and queue its expectation
   task automatic drive(input logic rs, input string tag,
      input logic idv, input int id, input logic [1:0] isv, input int is0, input int is1,
      input logic jdv, input int jd, input logic [1:0] jsv, input int js0, input int js1);
      @(negedge clk);
      rst       = rs;
      i_dst_vld = idv;  i_dst_id = RW'(id);
      i_src_vld = isv;  i_src_id = {RW'(is1), RW'(is0)};
      j_dst_vld = jdv;  j_dst_id = RW'(jd);
      j_src_vld = jsv;  j_src_id = {RW'(js1), RW'(js0)};
      exp_q.push_back(rs ? 3'b000 :
         model(idv, RW'(id), isv, RW'(is0), RW'(is1), jdv, RW'(jd), jsv, RW'(js0), RW'(js1)));
      tag_q.push_back(tag);
   endtask

   // monitor: mid high phase, after the edge that captured the queued pattern
   always begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if ({raw_o, war_o, waw_o} !== e || any_o !== (|e)) begin
            n_fail++;
            $display("FAIL %s: raw/war/waw/any = %b%b%b%b, expected %b%b",
                     t, raw_o, war_o, waw_o, any_o, e, |e);
         end
      end
   end

   initial begin
      // R8: reset with hazardous inputs present
      drive(1, "R8 reset", 1, 3, 2'b11, 3, 3, 1, 3, 2'b11, 3, 3);
      drive(1, "R8 reset", 1, 3, 2'b11, 3, 3, 1, 3, 2'b11, 3, 3);
      // R4: i=R3<-R2+R1, j=R2<-R3+imm (slot 1 invalid)
      drive(0, "R4 example", 1, 3, 2'b11, 2, 1, 1, 2, 2'b01, 3, 0);
      // R1 raw only
      drive(0, "R1 raw", 1, 7, 2'b11, 8, 9, 1, 11, 2'b11, 7, 12);
      // R2 war only
      drive(0, "R2 war", 1, 13, 2'b11, 14, 15, 1, 15, 2'b11, 16, 17);
      // R3 waw only
      drive(0, "R3 waw", 1, 5, 2'b11, 6, 7, 1, 5, 2'b11, 8, 9);
      // R9 match only through slot 1
      drive(0, "R9 slot1", 1, 10, 2'b11, 20, 21, 1, 22, 2'b11, 1, 10);
      // R5 invalid i destination with matching id
      drive(0, "R5 dst invalid", 0, 3, 2'b11, 4, 4, 1, 3, 2'b11, 3, 3);
      // R5 immediate in j slot with matching id
      drive(0, "R5 immediate", 1, 18, 2'b00, 18, 18, 0, 18, 2'b00, 18, 18);
      // R5 register 0 compares normally
      drive(0, "R5 reg0", 1, 0, 2'b01, 30, 0, 1, 31, 2'b01, 0, 0);
      // R6 none set
      drive(0, "R6 none", 1, 1, 2'b11, 2, 3, 1, 4, 2'b11, 5, 6);
      // R6 all three set
      drive(0, "R6 all", 1, 4, 2'b11, 4, 6, 1, 4, 2'b11, 4, 6);
      // R10 both j sources equal i destination
      drive(0, "R10 dup", 1, 9, 2'b11, 1, 2, 1, 19, 2'b11, 9, 9);
      // R7 back-to-back change
      drive(0, "R7 latency", 1, 25, 2'b11, 26, 27, 1, 25, 2'b00, 0, 0);
      drive(0, "R7 latency", 1, 25, 2'b11, 26, 27, 1, 24, 2'b00, 0, 0);
      // R8 reset mid-stream
      drive(1, "R8 mid reset", 1, 4, 2'b11, 4, 6, 1, 4, 2'b11, 4, 6);
      drive(0, "R8 after reset", 1, 4, 2'b11, 4, 6, 1, 4, 2'b11, 4, 6);
      // R2 war through slot 1 of i
      drive(0, "R2 war slot1", 1, 2, 2'b10, 29, 28, 1, 28, 2'b00, 0, 0);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule